// File: doc/BRIEF.md
# Poisoned Packet Downstream Filter

This block sits on the downstream packet path as a single registered pipeline stage. Each packet arrives as a set of header fields: a poisoned-data flag, a flag that says whether the packet carries data, a virtual channel number, an unsupported-transaction flag and a tag. The same fields leave one cycle later. The unsupported-transaction flag may be forced to 1 on the way through, so that stages further downstream master-abort the packet.

A 32-bit control register holds one enable bit. While the enable is clear, packets pass untouched. Once software sets it, the filter watches for a poisoned packet. That packet is marked unsupported, and the filter arms itself. From then on, every data-carrying packet on every virtual channel is marked unsupported. Requests without data, such as reads, still go through unmarked. The armed state is sticky. It ends only on reset or when software writes the enable back to 0.

The control logic is a three-state machine:
- `ST_OFF`: filter disabled.
- `ST_WATCH`: enabled, no poison seen yet.
- `ST_ARMED`: enabled, poison seen.

Its transitions are:
- OFF→WATCH when the enable is written to 1.
- WATCH→ARMED when a poisoned packet is accepted.
- WATCH→OFF and ARMED→OFF when the enable is written to 0.
- Every other case holds the current state, including a write of 1 while ARMED.

The enable bit that software reads back is simply "state is not OFF".

Top module: `poison_drop_filter`

## Requirements
- R1: After reset, `out_valid` is 0, `poison_seen` is 0 and the control register reads 0x00000000.
- R2: The control register sits at offset 0xAC, and its bit 31 is the enable. Bits 30:0 always read 0. Any other offset reads 0, and writes to any other offset have no effect on the enable.
- R3: While the enable is 0, every packet leaves with all its fields equal to the input, including poisoned packets, and `poison_seen` stays 0.
- R4: While the enable is 1, an accepted packet with the poison flag set leaves with the unsupported flag at 1. `poison_seen` is 1 from the cycle after its acceptance.
- R5: Once armed, every later packet with the has-data flag set leaves with the unsupported flag at 1, whatever its virtual channel.
- R6: A packet with has-data 0 and poison 0 leaves with its unsupported flag unchanged, even while armed.
- R7: While the enable is 1 but not yet armed, non-poisoned packets pass unmodified.
- R8: Writing the enable to 0 clears `poison_seen` in the next cycle, and later packets pass unmodified. Writing 1 while armed keeps the filter armed.
- R9: A packet that arrives with the unsupported flag at 1 leaves with it at 1 in every state.
- R10: A packet accepted at a clock edge (`in_valid` and `in_ready` both 1) appears on the output right after that edge. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is 1 and `out_ready` is 0, the output holds still.
- R11: Packets leave in the order they were accepted, with tag, virtual channel, poison and has-data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr` (combinational) |
| in_valid | input | 1 | Input packet valid |
| in_ready | output | 1 | Stage can accept a packet |
| in_poison | input | 1 | Packet has poisoned data |
| in_has_data | input | 1 | Packet carries data |
| in_vc | input | 3 | Virtual channel |
| in_ut | input | 1 | Incoming unsupported-transaction flag |
| in_tag | input | 8 | Packet tag |
| out_valid | output | 1 | Output packet valid |
| out_ready | input | 1 | Downstream accepts the packet |
| out_poison | output | 1 | Poison flag, passed through |
| out_has_data | output | 1 | Has-data flag, passed through |
| out_vc | output | 3 | Virtual channel, passed through |
| out_ut | output | 1 | Unsupported flag, possibly forced to 1 |
| out_tag | output | 8 | Packet tag, passed through |
| poison_seen | output | 1 | Sticky armed indication |

## Verification
The assertions assume that `in_valid` and the packet fields stay stable while a packet waits for `in_ready`. They also assume that a register write and a packet acceptance that depend on each other are never expected to resolve within a single cycle. The stimulus follows both rules: the driver holds each packet's fields from its first offer until it is accepted, and register writes are issued only between packets. Backpressure on `out_ready` is pseudo-random with stretches held low, so that the stall-hold and ordering properties are exercised while the scoreboard tracks the expected unsupported flag with its own enable and armed model.

// File: rtl/pdf_pkg.sv
package pdf_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_WATCH = 2'd1,
        ST_ARMED = 2'd2
    } arm_state_t;

    localparam int CFG_DATA_W = 32;

endpackage

// File: rtl/pdf_cfg_decode.sv
module pdf_cfg_decode #(
    parameter int          ADDR_W   = 8,
    parameter int          DATA_W   = 32,
    parameter int          EN_BIT   = 31,
    parameter logic [7:0]  CTRL_OFS = 8'hAC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              enabled,
    output logic              en_set,
    output logic              en_clr,
    output logic [DATA_W-1:0] cfg_rdata
);

    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(CTRL_OFS);

    logic hit;
    logic unused_wdata;

    assign hit          = (cfg_addr == OFS);
    assign en_set       = cfg_wr && hit &&  cfg_wdata[EN_BIT];
    assign en_clr       = cfg_wr && hit && !cfg_wdata[EN_BIT];
    assign unused_wdata = ^cfg_wdata;

    always_comb begin
        cfg_rdata = '0;
        if (hit) begin
            cfg_rdata[EN_BIT] = enabled;
        end
    end

    // R2: every bit except the enable reads as zero
    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata & ~(DATA_W'(1) << EN_BIT)) == '0);

    // R2: a write elsewhere leaves the enable alone
    p_other_ofs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !hit) |-> !(en_set || en_clr));

endmodule

// File: rtl/pdf_arm_fsm.sv
module pdf_arm_fsm
    import pdf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_set,
    input  logic en_clr,
    input  logic pkt_acc,
    input  logic pkt_poison,
    input  logic pkt_has_data,
    output logic enabled,
    output logic armed,
    output logic force_ut
);

    arm_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (en_set) state_d = ST_WATCH;
            end
            ST_WATCH: begin
                if (en_clr)                       state_d = ST_OFF;
                else if (pkt_acc && pkt_poison)   state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (en_clr) state_d = ST_OFF;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_comb begin
        enabled  = 1'b0;
        armed    = 1'b0;
        force_ut = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                force_ut = 1'b0;
            end
            ST_WATCH: begin
                enabled  = 1'b1;
                force_ut = pkt_poison;
            end
            ST_ARMED: begin
                enabled  = 1'b1;
                armed    = 1'b1;
                force_ut = pkt_poison || pkt_has_data;
            end
            default: begin
                force_ut = 1'b0;
            end
        endcase
    end

    // R5: armed state persists until the enable is cleared
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && !en_clr) |=> (state_q == ST_ARMED));

    // R8: clearing the enable always returns to OFF
    p_disarm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        en_clr |=> (state_q == ST_OFF));

    // R3: no arming while disabled
    p_off_stays_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF && !en_set) |=> (state_q == ST_OFF));

endmodule

// File: rtl/pdf_pipe_stage.sv
module pdf_pipe_stage #(
    parameter int VC_W  = 3,
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_poison,
    input  logic             in_has_data,
    input  logic [VC_W-1:0]  in_vc,
    input  logic             in_ut,
    input  logic [TAG_W-1:0] in_tag,
    input  logic             force_ut,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             out_poison,
    output logic             out_has_data,
    output logic [VC_W-1:0]  out_vc,
    output logic             out_ut,
    output logic [TAG_W-1:0] out_tag
);

    logic load;

    assign in_ready = !out_valid || out_ready;
    assign load     = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else if (in_ready) begin
            out_valid <= in_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_poison   <= 1'b0;
            out_has_data <= 1'b0;
            out_vc       <= '0;
            out_ut       <= 1'b0;
            out_tag      <= '0;
        end else if (load) begin
            out_poison   <= in_poison;
            out_has_data <= in_has_data;
            out_vc       <= in_vc;
            out_ut       <= in_ut || force_ut;
            out_tag      <= in_tag;
        end
    end

    // R10: stalled output holds still
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_tag)
            && $stable(out_ut) && $stable(out_vc)));

    // R10: an accepted packet is on the output one cycle later
    p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (out_valid && out_tag == $past(in_tag)));

    // R9: incoming unsupported flag is never lost
    p_ut_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (load && in_ut) |=> out_ut);

endmodule

// File: rtl/poison_drop_filter.sv
module poison_drop_filter #(
    parameter int         VC_W     = 3,
    parameter int         TAG_W    = 8,
    parameter int         ADDR_W   = 8,
    parameter int         EN_BIT   = 31,
    parameter logic [7:0] CTRL_OFS = 8'hAC
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cfg_wr,
    input  logic [ADDR_W-1:0]                cfg_addr,
    input  logic [pdf_pkg::CFG_DATA_W-1:0]   cfg_wdata,
    output logic [pdf_pkg::CFG_DATA_W-1:0]   cfg_rdata,
    input  logic                             in_valid,
    output logic                             in_ready,
    input  logic                             in_poison,
    input  logic                             in_has_data,
    input  logic [VC_W-1:0]                  in_vc,
    input  logic                             in_ut,
    input  logic [TAG_W-1:0]                 in_tag,
    output logic                             out_valid,
    input  logic                             out_ready,
    output logic                             out_poison,
    output logic                             out_has_data,
    output logic [VC_W-1:0]                  out_vc,
    output logic                             out_ut,
    output logic [TAG_W-1:0]                 out_tag,
    output logic                             poison_seen
);

    localparam int DW = pdf_pkg::CFG_DATA_W;

    logic en_set, en_clr, enabled, armed, force_ut, acc;

    assign acc         = in_valid && in_ready;
    assign poison_seen = armed;

    pdf_cfg_decode #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DW),
        .EN_BIT   (EN_BIT),
        .CTRL_OFS (CTRL_OFS)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .enabled   (enabled),
        .en_set    (en_set),
        .en_clr    (en_clr),
        .cfg_rdata (cfg_rdata)
    );

    pdf_arm_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_set       (en_set),
        .en_clr       (en_clr),
        .pkt_acc      (acc),
        .pkt_poison   (in_poison),
        .pkt_has_data (in_has_data),
        .enabled      (enabled),
        .armed        (armed),
        .force_ut     (force_ut)
    );

    pdf_pipe_stage #(
        .VC_W  (VC_W),
        .TAG_W (TAG_W)
    ) u_pipe (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .in_poison    (in_poison),
        .in_has_data  (in_has_data),
        .in_vc        (in_vc),
        .in_ut        (in_ut),
        .in_tag       (in_tag),
        .force_ut     (force_ut),
        .out_valid    (out_valid),
        .out_ready    (out_ready),
        .out_poison   (out_poison),
        .out_has_data (out_has_data),
        .out_vc       (out_vc),
        .out_ut       (out_ut),
        .out_tag      (out_tag)
    );

    // R3: disabled filter passes the flag through
    p_passthru_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !enabled) |=> (out_ut == $past(in_ut)));

    // R6: requests without data are never marked
    p_nodata_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !in_has_data && !in_poison) |=> (out_ut == $past(in_ut)));

    // R4: poisoned packet while enabled is marked and arms the filter
    p_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_poison && enabled && !en_clr) |=> (out_ut && poison_seen));

    // R11: header fields other than the flag pass unchanged
    p_fields_r11: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (out_vc == $past(in_vc) && out_has_data == $past(in_has_data)
                 && out_poison == $past(in_poison)));

endmodule

// File: tb/test_poison_drop_filter.sv
module test_poison_drop_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        in_poison = 1'b0, in_has_data = 1'b0, in_ut = 1'b0;
    logic [2:0]  in_vc = '0;
    logic [7:0]  in_tag = '0;
    logic        out_valid, out_ready = 1'b1;
    logic        out_poison, out_has_data, out_ut, poison_seen;
    logic [2:0]  out_vc;
    logic [7:0]  out_tag;

    int checks = 0;
    int failures = 0;
    logic [13:0] exp_q[$];
    logic en_m = 1'b0, armed_m = 1'b0;
    logic bp_en = 1'b0, hold_low = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    logic [7:0]  tag_n = 8'd1;

    always #4 clk = ~clk;

    poison_drop_filter i_poison_drop_filter (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .in_valid(in_valid), .in_ready(in_ready), .in_poison(in_poison),
        .in_has_data(in_has_data), .in_vc(in_vc), .in_ut(in_ut), .in_tag(in_tag),
        .out_valid(out_valid), .out_ready(out_ready), .out_poison(out_poison),
        .out_has_data(out_has_data), .out_vc(out_vc), .out_ut(out_ut),
        .out_tag(out_tag), .poison_seen(poison_seen)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // output ready driver, updated shortly after each rising edge
    always @(posedge clk) begin
        #2;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = hold_low ? 1'b0 : (bp_en ? lfsr[0] | lfsr[3] : 1'b1);
    end

    // monitor: a transfer happens at the next rising edge when both are high
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R11 unexpected output", {24'd0, out_tag}, 32'd0);
            end else begin
                logic [13:0] e;
                logic [13:0] a;
                e = exp_q.pop_front();
                a = {out_tag, out_vc, out_poison, out_has_data, out_ut};
                check(a == e, (a[0] != e[0]) ? "R4/R5/R6/R7/R9 ut flag" : "R11 order/fields",
                      {18'd0, a}, {18'd0, e});
            end
        end
    end

    task automatic send(input logic p, input logic d, input logic [2:0] vc, input logic ut);
        logic exp_ut;
        bit ok;
        @(negedge clk);
        in_valid = 1'b1; in_poison = p; in_has_data = d; in_vc = vc; in_ut = ut;
        in_tag = tag_n;
        forever begin
            #1;
            ok = in_ready;
            if (ok) begin
                exp_ut = ut | (en_m & (p | (armed_m & d)));
                exp_q.push_back({tag_n, vc, p, d, exp_ut});
                if (en_m && p) armed_m = 1'b1;
            end
            @(posedge clk);
            if (ok) break;
            @(negedge clk);
        end
        tag_n = tag_n + 8'd1;
        #1;
        in_valid = 1'b0;
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (a == 8'hAC) begin
            en_m = d[31];
            if (!d[31]) armed_m = 1'b0;
        end
    endtask

    task automatic drain();
        for (int i = 0; i < 2000 && exp_q.size() != 0; i++) @(negedge clk);
        check(exp_q.size() == 0, "R11 drain", exp_q.size(), 0);
    endtask

    initial begin
        #(8 * 200000);
        check(1'b0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        cfg_addr = 8'hAC; #1;
        check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        check(poison_seen == 1'b0, "R1 poison_seen", poison_seen, 0);
        check(cfg_rdata == 32'd0, "R1 ctrl reg", cfg_rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: disabled pass-through, poison does not arm
        send(1, 1, 3'd2, 0);
        send(0, 1, 3'd5, 1);
        send(0, 0, 3'd0, 0);
        drain();
        check(poison_seen == 1'b0, "R3 no arm while off", poison_seen, 0);

        // R2: writes elsewhere ignored, reserved bits zero
        cfg_write(8'hA8, 32'hFFFF_FFFF);
        cfg_addr = 8'hAC; #1;
        check(cfg_rdata == 32'd0, "R2 other offset ignored", cfg_rdata, 0);
        cfg_write(8'hAC, 32'hFFFF_FFFF);
        cfg_addr = 8'hAC; #1;
        check(cfg_rdata == 32'h8000_0000, "R2 enable readback", cfg_rdata, 32'h8000_0000);
        cfg_addr = 8'hB0; #1;
        check(cfg_rdata == 32'd0, "R2 other offset reads 0", cfg_rdata, 0);

        // R7: enabled, not armed
        send(0, 1, 3'd1, 0);
        send(0, 0, 3'd3, 0);
        drain();
        check(poison_seen == 1'b0, "R7 not armed", poison_seen, 0);

        // R4 + R10: poisoned packet, latency one cycle with ready high
        send(1, 1, 3'd4, 0);
        #1;
        check(out_valid == 1'b1, "R10 latency valid", out_valid, 1);
        check(out_ut == 1'b1, "R4 ut forced", out_ut, 1);
        check(poison_seen == 1'b1, "R4 poison_seen", poison_seen, 1);
        drain();

        // R5/R6/R9 while armed, with backpressure
        bp_en = 1'b1;
        for (int i = 0; i < 40; i++) begin
            send(1'b0, i[0], 3'(i), i[2] & i[1]);
        end
        drain();

        // R10: stall holds output
        hold_low = 1'b1;
        repeat (2) @(negedge clk);
        fork
            send(0, 1, 3'd6, 0);
        join_none
        repeat (4) @(negedge clk);
        #1;
        check(out_valid == 1'b1 && in_ready == 1'b0, "R10 stall", {out_valid, in_ready}, 2'b10);
        hold_low = 1'b0;
        wait fork;
        drain();

        // R8: writing 1 keeps armed, writing 0 disarms
        cfg_write(8'hAC, 32'h8000_0000);
        check(poison_seen == 1'b1, "R8 rewrite keeps armed", poison_seen, 1);
        cfg_write(8'hAC, 32'h0);
        check(poison_seen == 1'b0, "R8 disarm", poison_seen, 0);
        send(0, 1, 3'd7, 0);
        send(1, 1, 3'd0, 0);
        drain();

        // re-enable, mixed random traffic
        cfg_write(8'hAC, 32'h8000_0000);
        for (int i = 0; i < 60; i++) begin
            send(lfsr[5] & lfsr[9] & lfsr[1], lfsr[2], lfsr[8:6], lfsr[11] & lfsr[4]);
        end
        drain();
        bp_en = 1'b0;
        summary();
    end

endmodule